// File: doc/BRIEF.md
# Legacy Memory Window Route Decoder

This block sits in a host bridge and decides, for every processor access, where the access goes. Addresses in the legacy window from 0xA0000 to 0xFFFFF can go to local DRAM, either read/write or read-only. They can also be sent on to the expansion bus. A write to a read-only DRAM segment is reported as blocked and does not reach DRAM. Addresses outside the window always go to DRAM.

The routing comes from two sets of byte registers, written through a simple write port. The first set holds packed 2-bit attribute fields covering the shadow area: one field for the top 64 KB, and one field for each of twelve 16 KB segments starting at 0xC0000. The second is a control byte for the graphics window at 0xA0000–0xBFFFF. The graphics window is opened to DRAM either unconditionally, or only while the system-management mode input is high. Each time a mapping register is written, or the mode input changes, the block raises a one-cycle pulse so that later logic can flush anything it has cached about the mapping.

Top module: `legacy_map_decoder`

## Requirements
- R1: After synchronous reset every attribute field is 0 and the graphics control byte is 0x02. Every window address then routes to the bus (route code 1), and `map_changed` is low.
- R2: Any address below 0xA0000 or above 0xFFFFF routes to DRAM (route code 0), whatever the value of `wr`, `smm_active` or the registers.
- R3: Attribute value 3 routes reads and writes to DRAM (code 0). Value 1 routes reads to DRAM (code 0). Values 0 and 2 route reads and writes to the bus (code 1).
- R4: A write (`wr`=1) to a region whose attribute is 1 returns route code 2 (blocked).
- R5: The range 0xF0000–0xFFFFF takes its attribute from bits [5:4] of register 0x59.
- R6: Segment i (0..11) covers 0xC0000+0x4000*i for 16 KB. It takes its attribute from register 0x5A+(i>>1): bits [1:0] for even i and bits [5:4] for odd i. The other bits of these registers have no effect on routing.
- R7: The range 0xA0000–0xBFFFF routes to DRAM when bit 6 of register 0x72 is set, or when `smm_active` is high and bit 3 of register 0x72 is set. Otherwise it routes to the bus. A write to this range is never blocked.
- R8: `map_changed` is high for exactly the one cycle after a clock edge in which `cfg_we` wrote an address in 0x59–0x5F or 0x72, or in which `smm_active` differed from its value at the previous edge.
- R9: A write to any other register address changes neither the routing nor `map_changed`.
- R10: A register write changes the routing from the cycle after its clock edge, the same cycle as its `map_changed` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Physical address of the access |
| wr | input | 1 | 1 for a write access, 0 for a read |
| smm_active | input | 1 | System-management mode is active |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 8 | Register write data |
| route | output | 2 | 0 DRAM, 1 bus, 2 blocked write |
| map_changed | output | 1 | One-cycle pulse after a mapping trigger |

## Verification
Two triggers can land on the same clock edge: a write to the graphics control byte and a change of `smm_active`. The bench sets both up in the same cycle. It then checks that `map_changed` is high for only the next cycle and low in the one after it. It also checks that the graphics window routing reflects both the new byte and the new mode at once. A separate case raises the mode while a segment write is in flight, and judges the segment route and the graphics route together.

// File: rtl/lmap_pkg.sv
package lmap_pkg;

    typedef enum logic [1:0] {
        ROUTE_DRAM    = 2'd0,
        ROUTE_BUS     = 2'd1,
        ROUTE_BLOCKED = 2'd2
    } route_t;

    localparam int unsigned NUM_SEG    = 12;
    localparam int unsigned SEG_SHIFT  = 14;
    localparam int unsigned NUM_ATTR_REG = 7;

    localparam logic [19:0] WIN_LO   = 20'hA0000;
    localparam logic [19:0] SHADOW_LO = 20'hC0000;
    localparam logic [19:0] TOP_LO   = 20'hF0000;

    localparam logic [7:0] REG_TOP     = 8'h59;
    localparam logic [7:0] REG_SEG0    = 8'h5A;
    localparam logic [7:0] REG_ATTR_HI = 8'h5F;
    localparam logic [7:0] REG_GFX     = 8'h72;
    localparam logic [7:0] GFX_RESET   = 8'h02;

    localparam int unsigned GFX_OPEN_BIT = 6;
    localparam int unsigned GFX_EN_BIT   = 3;

    function automatic route_t attr_route(input logic [1:0] attr, input logic is_wr);
        route_t r;
        case (attr)
            2'd3:    r = ROUTE_DRAM;
            2'd1:    r = is_wr ? ROUTE_BLOCKED : ROUTE_DRAM;
            default: r = ROUTE_BUS;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lmap_regs.sv
module lmap_regs
    import lmap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smm_active,
    input  logic                 cfg_we,
    input  logic [7:0]           cfg_addr,
    input  logic [7:0]           cfg_wdata,
    output logic [1:0]           top_attr,
    output logic [NUM_SEG*2-1:0] seg_attr,
    output logic                 gfx_open,
    output logic                 gfx_en,
    output logic                 map_changed
);
    logic [7:0] attr_q [NUM_ATTR_REG];
    logic [7:0] gfx_q;
    logic       smm_q;
    logic       pulse_q;

    logic hit_attr, hit_gfx, trigger;

    assign hit_attr = cfg_we && (cfg_addr >= REG_TOP) && (cfg_addr <= REG_ATTR_HI);
    assign hit_gfx  = cfg_we && (cfg_addr == REG_GFX);
    assign trigger  = hit_attr || hit_gfx || (smm_active != smm_q);

    always_ff @(posedge clk) begin
        smm_q <= smm_active;
        if (rst) begin
            for (int k = 0; k < NUM_ATTR_REG; k++) attr_q[k] <= 8'h00;
            gfx_q   <= GFX_RESET;
            pulse_q <= 1'b0;
        end else begin
            if (hit_attr) attr_q[3'(cfg_addr - REG_TOP)] <= cfg_wdata;
            if (hit_gfx)  gfx_q <= cfg_wdata;
            pulse_q <= trigger;
        end
    end

    assign top_attr    = attr_q[0][5:4];
    assign gfx_open    = gfx_q[GFX_OPEN_BIT];
    assign gfx_en      = gfx_q[GFX_EN_BIT];
    assign map_changed = pulse_q;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        localparam int unsigned REG_IDX = 1 + g / 2;
        if (g % 2 == 0) begin : g_even
            assign seg_attr[g*2 +: 2] = attr_q[REG_IDX][1:0];
        end else begin : g_odd
            assign seg_attr[g*2 +: 2] = attr_q[REG_IDX][5:4];
        end
    end
endmodule

// File: rtl/lmap_route.sv
module lmap_route
    import lmap_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    input  logic                 smm_active,
    input  logic [1:0]           top_attr,
    input  logic [NUM_SEG*2-1:0] seg_attr,
    input  logic                 gfx_open,
    input  logic                 gfx_en,
    output route_t               route
);
    localparam logic [ADDR_W-1:0] WIN_HI_EXT = ADDR_W'(20'hFFFFF);
    localparam logic [ADDR_W-1:0] WIN_LO_EXT = ADDR_W'(WIN_LO);

    logic [19:0] low;
    logic [19:0] seg_off;
    logic [3:0]  seg_idx;
    logic        in_win;

    assign low     = addr[19:0];
    assign in_win  = (addr >= WIN_LO_EXT) && (addr <= WIN_HI_EXT);
    assign seg_off = low - SHADOW_LO;
    assign seg_idx = seg_off[SEG_SHIFT +: 4];

    always_comb begin
        route = ROUTE_DRAM;
        if (in_win) begin
            if (low >= TOP_LO) begin
                route = attr_route(top_attr, wr);
            end else if (low >= SHADOW_LO) begin
                route = attr_route(seg_attr[seg_idx*2 +: 2], wr);
            end else begin
                route = (gfx_open || (smm_active && gfx_en)) ? ROUTE_DRAM : ROUTE_BUS;
            end
        end
    end
endmodule

// File: rtl/legacy_map_decoder.sv
module legacy_map_decoder
    import lmap_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              smm_active,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [1:0]        route,
    output logic              map_changed
);
    logic [1:0]           top_attr;
    logic [NUM_SEG*2-1:0] seg_attr;
    logic                 gfx_open, gfx_en;
    route_t               route_w;

    lmap_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .smm_active  (smm_active),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .top_attr    (top_attr),
        .seg_attr    (seg_attr),
        .gfx_open    (gfx_open),
        .gfx_en      (gfx_en),
        .map_changed (map_changed)
    );

    lmap_route #(.ADDR_W(ADDR_W)) u_route (
        .addr       (addr),
        .wr         (wr),
        .smm_active (smm_active),
        .top_attr   (top_attr),
        .seg_attr   (seg_attr),
        .gfx_open   (gfx_open),
        .gfx_en     (gfx_en),
        .route      (route_w)
    );

    assign route = route_w;
endmodule

// File: rtl/lmap_checker.sv
module lmap_checker #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr,
    input logic              smm_active,
    input logic              cfg_we,
    input logic [7:0]        cfg_addr,
    input logic [1:0]        route,
    input logic              map_changed
);
    logic map_hit;
    logic outside;
    assign map_hit = cfg_we && (((cfg_addr >= 8'h59) && (cfg_addr <= 8'h5F)) || (cfg_addr == 8'h72));
    assign outside = (addr < ADDR_W'(20'hA0000)) || (addr > ADDR_W'(20'hFFFFF));

    a_r2_outside_dram: assert property (@(posedge clk) disable iff (rst)
        outside |-> route == 2'd0);

    a_r4_blocked_only_on_write: assert property (@(posedge clk) disable iff (rst)
        route == 2'd2 |-> wr);

    a_r3_valid_code: assert property (@(posedge clk) disable iff (rst)
        route != 2'd3);

    a_r8_pulse_on_cfg: assert property (@(posedge clk) disable iff (rst)
        map_hit |=> map_changed);

    a_r8_pulse_on_smm: assert property (@(posedge clk) disable iff (rst)
        !$stable(smm_active) |=> map_changed);

    a_r9_no_spurious_pulse: assert property (@(posedge clk) disable iff (rst)
        (!map_hit && $stable(smm_active)) |=> !map_changed);
endmodule

bind legacy_map_decoder lmap_checker #(.ADDR_W(ADDR_W)) u_lmap_checker (
    .clk         (clk),
    .rst         (rst),
    .addr        (addr),
    .wr          (wr),
    .smm_active  (smm_active),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .route       (route),
    .map_changed (map_changed)
);

// File: tb/legacy_map_decoder_tb.sv
module legacy_map_decoder_tb_top;
    localparam int unsigned ADDR_W = 32;
    localparam logic [1:0] DRAM = 2'd0, BUS = 2'd1, BLK = 2'd2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr = 1'b0;
    logic              smm_active = 1'b0;
    logic              cfg_we = 1'b0;
    logic [7:0]        cfg_addr = 8'h00;
    logic [7:0]        cfg_wdata = 8'h00;
    logic [1:0]        route;
    logic              map_changed;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    legacy_map_decoder #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr(wr), .smm_active(smm_active),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .route(route), .map_changed(map_changed)
    );

    // {addr[31:0], wr, smm, expected route[1:0]}
    localparam int NV = 17;
    localparam logic [35:0] VEC [NV] = '{
        {32'h000F0000, 1'b0, 1'b0, DRAM},  // R5 top attr 3
        {32'h000FFFFF, 1'b1, 1'b0, DRAM},  // R5
        {32'h000C0000, 1'b0, 1'b0, DRAM},  // R6 seg0 attr 1 read
        {32'h000C3FFF, 1'b1, 1'b0, BLK },  // R4 seg0 write
        {32'h000C4000, 1'b0, 1'b0, BUS },  // R6 seg1 attr 2
        {32'h000C8000, 1'b1, 1'b0, DRAM},  // R3 seg2 attr 3
        {32'h000CFFFF, 1'b1, 1'b0, DRAM},  // R6 seg3 attr 3
        {32'h000D0000, 1'b0, 1'b0, BUS },  // R6 stray bits ignored
        {32'h000D7FFF, 1'b1, 1'b0, BUS },  // R6 seg5
        {32'h000E8000, 1'b0, 1'b0, BUS },  // R6 seg10 attr 0
        {32'h000EC000, 1'b0, 1'b0, DRAM},  // R6 seg11 attr 1
        {32'h000EFFFF, 1'b1, 1'b0, BLK },  // R4 seg11 write
        {32'h000A0000, 1'b0, 1'b0, BUS },  // R7 enable only, no smm
        {32'h000BFFFF, 1'b1, 1'b1, DRAM},  // R7 enable with smm
        {32'h0009FFFF, 1'b1, 1'b0, DRAM},  // R2 below window
        {32'h00100000, 1'b1, 1'b1, DRAM},  // R2 above window
        {32'h00000000, 1'b0, 1'b0, DRAM}   // R2
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic probe(input logic [31:0] a, input logic w, input string req, input logic [1:0] exp);
        @(negedge clk);
        addr = a; wr = w;
        #1 check(req, route, exp);
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        #1 check("R1 pulse", {1'b0, map_changed}, 2'd0);
        probe(32'h000F0000, 1'b0, "R1 top", BUS);
        probe(32'h000C0000, 1'b1, "R1 seg", BUS);
        probe(32'h000A0000, 1'b0, "R1 gfx", BUS);

        // Program the table setup
        cfg_write(8'h59, 8'h30);
        cfg_write(8'h5A, 8'h21);
        cfg_write(8'h5B, 8'h33);
        cfg_write(8'h5C, 8'hCC);
        cfg_write(8'h5F, 8'h10);
        cfg_write(8'h72, 8'h0A);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            addr = VEC[i][35:4]; wr = VEC[i][3]; smm_active = VEC[i][2];
            #1 check($sformatf("R3/R6 vec %0d", i), route, VEC[i][1:0]);
        end
        @(negedge clk); smm_active = 1'b0;
        repeat (2) @(negedge clk);

        // R8 + R10: pulse timing and route update in the same cycle
        addr = 32'h000C4000; wr = 1'b0;
        cfg_we = 1'b1; cfg_addr = 8'h5A; cfg_wdata = 8'h31;
        #1 check("R10 before edge", route, BUS);
        @(posedge clk); #1;
        check("R8 pulse", {1'b0, map_changed}, 2'd1);
        check("R10 after edge", route, DRAM);
        @(negedge clk); cfg_we = 1'b0;
        @(posedge clk); #1;
        check("R8 pulse one cycle", {1'b0, map_changed}, 2'd0);

        // R9 unrelated register: no pulse, no routing change
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h58; cfg_wdata = 8'hFF;
        @(posedge clk); #1;
        check("R9 no pulse 0x58", {1'b0, map_changed}, 2'd0);
        @(negedge clk); cfg_addr = 8'h60;
        @(posedge clk); #1;
        check("R9 no pulse 0x60", {1'b0, map_changed}, 2'd0);
        @(negedge clk); cfg_we = 1'b0;
        probe(32'h000F0000, 1'b1, "R9 top unchanged", DRAM);
        probe(32'h000E8000, 1'b0, "R9 seg10 unchanged", BUS);

        // R8 smm change alone
        @(negedge clk); smm_active = 1'b1;
        @(posedge clk); #1;
        check("R8 smm pulse", {1'b0, map_changed}, 2'd1);
        @(posedge clk); #1;
        check("R8 smm pulse ends", {1'b0, map_changed}, 2'd0);
        @(negedge clk); smm_active = 1'b0;
        @(posedge clk); #1;
        check("R8 smm fall pulse", {1'b0, map_changed}, 2'd1);

        // Same-cycle: gfx write (open, no enable) and smm rising
        @(negedge clk);
        addr = 32'h000B0000; wr = 1'b1;
        cfg_we = 1'b1; cfg_addr = 8'h72; cfg_wdata = 8'h40;
        smm_active = 1'b1;
        @(posedge clk); #1;
        check("R8 joint pulse", {1'b0, map_changed}, 2'd1);
        check("R7 open write", route, DRAM);
        @(negedge clk); cfg_we = 1'b0;
        @(posedge clk); #1;
        check("R8 joint pulse single", {1'b0, map_changed}, 2'd0);
        @(negedge clk); smm_active = 1'b0;
        #1 check("R7 open without smm", route, DRAM);

        // R7: enable bit off, smm on -> bus
        cfg_write(8'h72, 8'h00);
        @(negedge clk); smm_active = 1'b1;
        #1 check("R7 smm without enable", route, BUS);
        @(negedge clk); smm_active = 1'b0;

        // Segment write in flight with smm rising
        @(negedge clk);
        addr = 32'h000DC000; wr = 1'b0;
        cfg_we = 1'b1; cfg_addr = 8'h5D; cfg_wdata = 8'h30;
        smm_active = 1'b1;
        @(posedge clk); #1;
        check("R6 seg7 new attr", route, DRAM);
        check("R8 pulse seg+smm", {1'b0, map_changed}, 2'd1);
        @(negedge clk); cfg_we = 1'b0;
        probe(32'h000D8000, 1'b0, "R6 seg6 still bus", BUS);
        probe(32'h000A0000, 1'b0, "R7 smm no enable", BUS);

        // R2 outside window even with blocking attrs everywhere
        cfg_write(8'h59, 8'h10);
        probe(32'h000FFFFF, 1'b1, "R4 top blocked", BLK);
        probe(32'h00FFFFFF, 1'b1, "R2 high", DRAM);

        // R1 reset again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; smm_active = 1'b0;
        probe(32'h000FFFFF, 1'b1, "R1 after reset", BUS);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule